// File: doc/BRIEF.md
# Three-Floor Elevator Controller

This block is the synchronous control core for a car that serves a ground floor, a first floor and a second floor. It keeps the car's position as a one-hot floor register. It gathers the hall and car call buttons into one request line per floor. When the door is reported closed, it moves the car directly to the requested floor in a single clock. A move of two floors also takes one clock, with no stop on the way.

Beside the floor register there is a door-open counter. It advances while the door is open, clears while the door is closed, and stops at its maximum value. At that value it raises a flag that a supervisor can treat as a door timeout. A combinational decoder turns the floor register into a seven-segment digit.

Top module: `elev_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the floor register at ground (001) and the door counter at zero on the next clock edge.
- R2: The floor output is always one-hot: ground = 001, first = 010, second = 100.
- R3: Each floor has its own request line. Ground is the OR of `btn[0]` (hall up) and `btn[1]` (car). First is the OR of `btn[2]` (hall up), `btn[3]` (hall down) and `btn[4]` (car). Second is the OR of `btn[5]` (hall down) and `btn[6]` (car). With `door_close`=1, an active request loads its floor on the next edge.
- R4: A move between ground and second takes one clock, with no intermediate floor.
- R5: A request for the current floor leaves the floor unchanged.
- R6: While `door_close`=0, the floor holds whatever the requests are.
- R7: When several floors are requested in the same cycle, the lowest-numbered floor wins.
- R8: With `door_close`=1 and no request, the floor holds.
- R9: While `door_close`=1, the door counter clears to zero on the next edge, even if `door_open`=1.
- R10: With `door_open`=1 and `door_close`=0, the counter goes up by one per clock. With both low, it holds.
- R11: The counter stops at 255 (its all-ones value). `door_timeout` is 1 exactly when the count is 255.
- R12: `seg` drives segments a..g on bits 0..6, active high: ground shows 7'h3F ("0"), first shows 7'h06 ("1"), second shows 7'h5B ("2"). A value that is not one-hot blanks the display (7'h00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | 7 | Call buttons, grouped by floor as listed in R3 |
| door_open | input | 1 | Door reported open |
| door_close | input | 1 | Door reported closed; permits moves |
| floor | output | 3 | One-hot current floor |
| door_count | output | 8 | Door-open counter |
| door_timeout | output | 1 | Counter is at its maximum |
| seg | output | 7 | Seven-segment digit, bit 0 = a through bit 6 = g |

## Verification
If the floor register held a wrong value, the error would appear on `floor` and `seg` on the very next sampled cycle. It would not be hidden behind a pipeline, so each vector compares both outputs one clock after its stimulus. A counter that clears late, or that wraps instead of stopping, would show on `door_count` and `door_timeout` on the first cycle past the boundary. The bench therefore samples at the clear and at the saturation point.

// File: rtl/elev_pkg.sv
package elev_pkg;
    localparam int NUM_FLOORS = 3;
    localparam int NUM_BTNS   = 7;
    localparam int SEG_W      = 7;

    typedef logic [NUM_FLOORS-1:0] floor_t;

    localparam floor_t FLOOR_GND = 3'b001;
    localparam floor_t FLOOR_FIRST = 3'b010;
    localparam floor_t FLOOR_SECOND = 3'b100;

    // bit 0 = segment a ... bit 6 = segment g
    localparam logic [SEG_W-1:0] SEG_DIGIT0 = 7'h3F;
    localparam logic [SEG_W-1:0] SEG_DIGIT1 = 7'h06;
    localparam logic [SEG_W-1:0] SEG_DIGIT2 = 7'h5B;
    localparam logic [SEG_W-1:0] SEG_BLANK  = 7'h00;
endpackage

// File: rtl/elev_req_decode.sv
module elev_req_decode
    import elev_pkg::*;
(
    input  logic [NUM_BTNS-1:0] btn,
    output floor_t              target,
    output logic                any_req
);
    floor_t req;

    always_comb begin
        req[0] = btn[0] | btn[1];
        req[1] = btn[2] | btn[3] | btn[4];
        req[2] = btn[5] | btn[6];
    end

    // lowest-numbered requested floor wins
    always_comb begin
        target = '0;
        for (int i = NUM_FLOORS - 1; i >= 0; i--) begin
            if (req[i]) begin
                target    = '0;
                target[i] = 1'b1;
            end
        end
        any_req = |req;
    end
endmodule

// File: rtl/elev_floor_reg.sv
module elev_floor_reg
    import elev_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   move_ok,
    input  logic   any_req,
    input  floor_t target,
    output floor_t floor
);
    typedef struct packed {
        floor_t pos;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if ($countones(st_q.pos) != 1) begin
            st_d.pos = FLOOR_GND;
        end else if (move_ok && any_req) begin
            st_d.pos = target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pos <= FLOOR_GND;
        end else begin
            st_q <= st_d;
        end
    end

    assign floor = st_q.pos;
endmodule

// File: rtl/elev_door_timer.sv
module elev_door_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             is_open,
    input  logic             is_closed,
    output logic [CNT_W-1:0] count,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (is_closed) begin
            tmr_d.cnt = '0;
        end else if (is_open && (tmr_q.cnt != CNT_MAX)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign count  = tmr_q.cnt;
    assign at_max = (tmr_q.cnt == CNT_MAX);
endmodule

// File: rtl/elev_seg_decode.sv
module elev_seg_decode
    import elev_pkg::*;
(
    input  floor_t             floor,
    output logic [SEG_W-1:0]   seg
);
    always_comb begin
        unique case (floor)
            FLOOR_GND:    seg = SEG_DIGIT0;
            FLOOR_FIRST:  seg = SEG_DIGIT1;
            FLOOR_SECOND: seg = SEG_DIGIT2;
            default:      seg = SEG_BLANK;
        endcase
    end
endmodule

// File: rtl/elev_ctrl.sv
module elev_ctrl
    import elev_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [6:0]       btn,
    input  logic             door_open,
    input  logic             door_close,
    output logic [2:0]       floor,
    output logic [CNT_W-1:0] door_count,
    output logic             door_timeout,
    output logic [6:0]       seg
);
    floor_t target;
    logic   any_req;

    elev_req_decode u_req (
        .btn     (btn),
        .target  (target),
        .any_req (any_req)
    );

    elev_floor_reg u_floor (
        .clk     (clk),
        .rst     (rst),
        .move_ok (door_close),
        .any_req (any_req),
        .target  (target),
        .floor   (floor)
    );

    elev_door_timer #(.CNT_W(CNT_W)) u_door (
        .clk       (clk),
        .rst       (rst),
        .is_open   (door_open),
        .is_closed (door_close),
        .count     (door_count),
        .at_max    (door_timeout)
    );

    elev_seg_decode u_seg (
        .floor (floor),
        .seg   (seg)
    );
endmodule

// File: rtl/elev_ctrl_checker.sv
module elev_ctrl_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [6:0]       btn,
    input logic             door_open,
    input logic             door_close,
    input logic [2:0]       floor,
    input logic [CNT_W-1:0] door_count,
    input logic [6:0]       seg
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    assert_reset_ground_R1: assert property (@(posedge clk)
        rst |=> (floor == 3'b001 && door_count == '0));

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(floor) == 1);

    assert_hold_open_R6: assert property (@(posedge clk) disable iff (rst)
        !door_close |=> $stable(floor));

    assert_low_priority_R7: assert property (@(posedge clk) disable iff (rst)
        (door_close && (btn[0] || btn[1])) |=> floor == 3'b001);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (door_close && btn == 7'd0) |=> $stable(floor));

    assert_close_clear_R9: assert property (@(posedge clk) disable iff (rst)
        door_close |=> door_count == '0);

    assert_saturate_R11: assert property (@(posedge clk) disable iff (rst)
        (door_count == CMAX && !door_close) |=> door_count == CMAX);

    assert_digit_R12: assert property (@(posedge clk) disable iff (rst)
        floor == 3'b100 |-> seg == 7'h5B);
endmodule

bind elev_ctrl elev_ctrl_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .btn        (btn),
    .door_open  (door_open),
    .door_close (door_close),
    .floor      (floor),
    .door_count (door_count),
    .seg        (seg)
);

// File: tb/elev_ctrl_bench.sv
module elev_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] btn = '0;
    logic       door_open = 1'b0;
    logic       door_close = 1'b0;
    logic [2:0] floor;
    logic [7:0] door_count;
    logic       door_timeout;
    logic [6:0] seg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    elev_ctrl u_elev_ctrl (
        .clk(clk), .rst(rst), .btn(btn), .door_open(door_open),
        .door_close(door_close), .floor(floor), .door_count(door_count),
        .door_timeout(door_timeout), .seg(seg)
    );

    // {close, open, btn[6:0], expected floor[2:0]}
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 1'b0, 7'b1000000, 3'b100},  // R4 ground -> second
        {1'b1, 1'b0, 7'b0000001, 3'b001},  // R4 second -> ground
        {1'b0, 1'b1, 7'b0010000, 3'b001},  // R6 door open
        {1'b0, 1'b0, 7'b0100000, 3'b001},  // R6 door neither
        {1'b1, 1'b0, 7'b0001000, 3'b010},  // R3 hall down first
        {1'b1, 1'b0, 7'b0010000, 3'b010},  // R5 same floor
        {1'b1, 1'b0, 7'b0000000, 3'b010},  // R8 no request
        {1'b1, 1'b0, 7'b1000010, 3'b001},  // R7 ground beats second
        {1'b1, 1'b0, 7'b0100100, 3'b010},  // R7 first beats second
        {1'b1, 1'b0, 7'b0100000, 3'b100},  // R3 hall down second
        {1'b1, 1'b0, 7'b0000100, 3'b010},  // R3 hall up first
        {1'b1, 1'b0, 7'b0000010, 3'b001}   // R3 car ground
    };

    function automatic logic [6:0] exp_seg(input logic [2:0] f);
        case (f)
            3'b001:  return 7'h3F;
            3'b010:  return 7'h06;
            3'b100:  return 7'h5B;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        rst = 1'b0;
        check("R1 floor", floor, 3'b001);
        check("R1 count", door_count, 0);
        check("R12 digit0", seg, 7'h3F);

        for (int i = 0; i < NV; i++) begin
            door_close = VEC[i][11];
            door_open  = VEC[i][10];
            btn        = VEC[i][9:3];
            tick();
            check("R2-R8 vector floor", floor, VEC[i][2:0]);
            check("R12 vector seg", seg, exp_seg(VEC[i][2:0]));
        end
        btn = '0;

        // R10 counting while open
        door_close = 1'b0;
        door_open = 1'b1;
        for (int i = 0; i < 10; i++) tick();
        check("R10 count up", door_count, 10);
        door_open = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        check("R10 hold idle", door_count, 10);

        // R9 close clears even with open
        door_open = 1'b1;
        door_close = 1'b1;
        tick();
        check("R9 clear", door_count, 0);

        // R11 saturation and timeout flag
        door_close = 1'b0;
        for (int i = 0; i < 254; i++) tick();
        check("R11 at 254", door_count, 254);
        check("R11 no timeout", door_timeout, 0);
        tick();
        check("R11 at 255", door_count, 255);
        check("R11 timeout", door_timeout, 1);
        for (int i = 0; i < 5; i++) tick();
        check("R11 saturated", door_count, 255);
        door_close = 1'b1;
        door_open = 1'b0;
        tick();
        check("R9 clear after sat", door_count, 0);
        check("R11 timeout low", door_timeout, 0);

        // R1 reset from second floor with count running
        btn = 7'b1000000;
        tick();
        check("R4 to second", floor, 3'b100);
        btn = '0;
        door_close = 1'b0;
        door_open = 1'b1;
        tick();
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1 reset floor", floor, 3'b001);
        check("R1 reset count", door_count, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule